// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer Bank

The block holds three independent 16-bit up-counters, each with its own prescaler, compare register, compare output pin and interrupt line, all reached over a small byte-wide register bus. Software picks the count clock and counting edge per channel, loads a compare value and, if it wants a fixed period, has the counter return to zero on a compare match. One shared run register starts and halts any set of channels in the same cycle.

Every channel raises a sticky compare flag and a sticky overflow flag. A flag is cleared by a two-step handshake: software reads the status register, then writes 0 to the flag bit. This means that an event arriving between the read and the write is never lost. Each interrupt line is a level that stays high for as long as an enabled flag is set. The compare output pin is loaded with an initial level when its action code is written, and each match then clears, sets or toggles it.

Top module: `tmr_array`

## Requirements
- R1: After reset, every register reads 0, all counters are stopped, and every compare output and interrupt line is 0.
- R2: Channel n occupies addresses 16*n to 16*n+15, and the run register is at address 0x30. Within a channel: control at +0, mode at +1, output action at +2, interrupt enable at +4, status at +5, counter low/high at +6/+7, compare low/high at +8/+9. Bit n of the run register runs channel n. A counter changes only while its run bit is 1, or when the counter is written.
- R3: Control bits [2:0] set the count clock to the bus clock divided by 1, 4, 16 or 64 for codes 0 to 3. Codes 4 to 7 divide by 64. The prescaler is held at 0 while the channel is stopped, so every start begins a fresh prescaler period.
- R4: Control bits [4:3] select the edge. Code 0 gives one tick at the end of each prescaler period. Code 1 gives one tick per period, offset by half a period. Code 2 gives a tick every half period. With divide-by-1, each code gives a tick every cycle.
- R5: When control bits [7:5] equal 1, a tick with the counter equal to the compare value loads 0, so the period is compare+1 ticks. Any other code lets the counter run freely and wrap from 0xFFFF to 0.
- R6: Status bit 0 (compare flag) sets on every tick where the counter equals the compare value.
- R7: Status bit 4 (overflow flag) sets on a tick where the counter wraps from 0xFFFF to 0 without a match clear.
- R8: Writing the output action field (bits [3:0]) loads the pin: codes 1 to 3 drive it to 0, codes 5 to 7 drive it to 1, and other codes leave it alone. On a compare match, codes 1/5 clear the pin, 2/6 set it and 3/7 toggle it. All other codes take no action.
- R9: Writing 0 to a status flag bit clears that flag only if it was 1 at the last status read. Writing 1 has no effect. An event in the same cycle as the clear wins.
- R10: Each interrupt line is the OR of compare flag AND enable bit 0 with overflow flag AND enable bit 4. It stays high until the flag is cleared.
- R11: A byte write to the counter replaces that byte and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, also the timer clock source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe (marks status as read) |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| cmp_o | output | 3 | Compare output pin per channel |
| irq_o | output | 3 | Level interrupt per channel |

## Verification
The hardest case to reach is a compare event that lands between the status read and the clearing write. To produce it, the bench reads the status while the flag is still 0. It then runs a divide-by-1 channel, with the counter preloaded to the compare value, for exactly one cycle, and only then writes the 0. The flag must survive that write. Prescaler phases are also difficult, because the tick position depends on the edge code and on the start time. Randomised runs over all dividers and edges are therefore stopped after a chosen number of cycles. The counter, flag and pin are then compared with tick counts computed from closed-form expressions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFF_CTRL  = 4'h0;
  localparam logic [3:0] OFF_MODE  = 4'h1;
  localparam logic [3:0] OFF_IOC   = 4'h2;
  localparam logic [3:0] OFF_IEN   = 4'h4;
  localparam logic [3:0] OFF_STS   = 4'h5;
  localparam logic [3:0] OFF_CNT_L = 4'h6;
  localparam logic [3:0] OFF_CNT_H = 4'h7;
  localparam logic [3:0] OFF_GR_L  = 4'h8;
  localparam logic [3:0] OFF_GR_H  = 4'h9;

  localparam logic [2:0] CLR_MATCH = 3'd1;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_e;

  // flag vector: [0] compare, [1] overflow
  localparam int FLG_N = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] div_sel_i,
  input  logic [1:0] edge_sel_i,
  output logic       tick_o
);
  import tmr_pkg::*;

  logic [PW-1:0] pcnt_q, wrap, half;
  logic [1:0]    shift;

  always_comb begin
    shift = div_sel_i[2] ? 2'd3 : div_sel_i[1:0];
    wrap  = (PW'(1) << {shift, 1'b0}) - PW'(1);
    half  = wrap >> 1;
    if (wrap == '0) begin
      tick_o = run_i;
    end else begin
      unique case (edge_sel_i)
        EDGE_FALL: tick_o = run_i && (pcnt_q == half);
        EDGE_BOTH: tick_o = run_i && (pcnt_q == half || pcnt_q == wrap);
        default:   tick_o = run_i && (pcnt_q == wrap);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pcnt_q <= '0;
    else if (!run_i || pcnt_q >= wrap) pcnt_q <= '0;
    else                              pcnt_q <= pcnt_q + PW'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [3:0]    off_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          flag_cmp_o,
  output logic          flag_ovf_o,
  output logic          cmp_o,
  output logic          irq_o
);
  import tmr_pkg::*;

  logic [7:0]       ctrl_q, mode_q, ioc_q, ien_q;
  logic [CW-1:0]    cnt_q, gr_q;
  logic [FLG_N-1:0] flg_q, seen_q, set_v, clr_v, wbits;
  logic             out_q, tick, match, clr_on, wr_cnt, cmp_evt, ovf_evt;

  tmr_prescaler #(.PW(6)) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .div_sel_i  (ctrl_q[2:0]),
    .edge_sel_i (ctrl_q[4:3]),
    .tick_o     (tick)
  );

  assign clr_on  = (ctrl_q[7:5] == CLR_MATCH);
  assign match   = tick && (cnt_q == gr_q);
  assign wr_cnt  = wr_i && (off_i == OFF_CNT_L || off_i == OFF_CNT_H);
  assign cmp_evt = match && !wr_cnt;
  assign ovf_evt = tick && !wr_cnt && (cnt_q == '1) && !(match && clr_on);
  assign set_v   = {ovf_evt, cmp_evt};
  assign wbits   = {wdata_i[4], wdata_i[0]};
  assign clr_v   = (wr_i && off_i == OFF_STS) ? (~wbits & seen_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      gr_q   <= '0;
    end else if (wr_i) begin
      unique case (off_i)
        OFF_CTRL: ctrl_q     <= wdata_i;
        OFF_MODE: mode_q     <= wdata_i;
        OFF_IOC:  ioc_q      <= wdata_i;
        OFF_IEN:  ien_q      <= wdata_i;
        OFF_GR_L: gr_q[7:0]  <= wdata_i;
        OFF_GR_H: gr_q[15:8] <= wdata_i;
        default: ;
      endcase
    end
  end

  // bus write wins over counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (wr_i && off_i == OFF_CNT_L)    cnt_q <= {cnt_q[15:8], wdata_i};
    else if (wr_i && off_i == OFF_CNT_H)    cnt_q <= {wdata_i, cnt_q[7:0]};
    else if (tick)                          cnt_q <= (match && clr_on) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q  <= '0;
      seen_q <= '0;
    end else begin
      flg_q  <= (flg_q & ~clr_v) | set_v;
      seen_q <= (rd_i && off_i == OFF_STS) ? flg_q : (seen_q & ~clr_v);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
    end else if (wr_i && off_i == OFF_IOC) begin
      if (!wdata_i[3] && wdata_i[1:0] != 2'd0) out_q <= wdata_i[2];
    end else if (cmp_evt && !ioc_q[3]) begin
      unique case (ioc_q[1:0])
        2'd1:    out_q <= 1'b0;
        2'd2:    out_q <= 1'b1;
        2'd3:    out_q <= ~out_q;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CTRL:  rdata_o = ctrl_q;
      OFF_MODE:  rdata_o = mode_q;
      OFF_IOC:   rdata_o = ioc_q;
      OFF_IEN:   rdata_o = ien_q;
      OFF_STS:   rdata_o = {3'b0, flg_q[1], 3'b0, flg_q[0]};
      OFF_CNT_L: rdata_o = cnt_q[7:0];
      OFF_CNT_H: rdata_o = cnt_q[15:8];
      OFF_GR_L:  rdata_o = gr_q[7:0];
      OFF_GR_H:  rdata_o = gr_q[15:8];
      default:   rdata_o = '0;
    endcase
  end

  assign cnt_o      = cnt_q;
  assign flag_cmp_o = flg_q[0];
  assign flag_ovf_o = flg_q[1];
  assign cmp_o      = out_q;
  assign irq_o      = |(flg_q & {ien_q[4], ien_q[0]});
endmodule

// File: rtl/tmr_array.sv
module tmr_array #(
  parameter  int N_CH   = 3,
  localparam int SEL_W  = $clog2(N_CH + 1),
  localparam int ADDR_W = SEL_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_CH-1:0]   cmp_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam logic [SEL_W-1:0] START_SEL = SEL_W'(N_CH);

  logic [SEL_W-1:0]          sel;
  logic [3:0]                off;
  logic [N_CH-1:0]           run_q, ch_fcmp, ch_fovf;
  logic [N_CH-1:0][7:0]      ch_rdata;
  logic [N_CH-1:0][15:0]     ch_cnt;

  assign sel = addr_i[ADDR_W-1:4];
  assign off = addr_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        run_q <= '0;
    else if (wr_en_i && sel == START_SEL && off == 4'h0) run_q <= wdata_i[N_CH-1:0];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_channel #(.CW(16)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q[g]),
      .wr_i       (wr_en_i && sel == SEL_W'(g)),
      .rd_i       (rd_en_i && sel == SEL_W'(g)),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .rdata_o    (ch_rdata[g]),
      .cnt_o      (ch_cnt[g]),
      .flag_cmp_o (ch_fcmp[g]),
      .flag_ovf_o (ch_fovf[g]),
      .cmp_o      (cmp_o[g]),
      .irq_o      (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (sel == START_SEL && off == 4'h0) rdata_o = 8'(run_q);
    for (int c = 0; c < N_CH; c++)
      if (sel == SEL_W'(c)) rdata_o = ch_rdata[c];
  end
endmodule

// File: rtl/tmr_array_chk.sv
module tmr_array_chk #(
  parameter int N_CH   = 3,
  parameter int ADDR_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [7:0]            wdata_i,
  input logic [N_CH-1:0]       run_q,
  input logic [N_CH-1:0][15:0] ch_cnt,
  input logic [N_CH-1:0]       ch_fcmp,
  input logic [N_CH-1:0]       ch_fovf,
  input logic [N_CH-1:0]       cmp_o,
  input logic [N_CH-1:0]       irq_o
);
  localparam int SEL_W = ADDR_W - 4;

  p_start_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(N_CH * 16)) |=> run_q == $past(wdata_i[N_CH-1:0]));

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    p_cnt_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[i] && !(wr_en_i && addr_i[ADDR_W-1:4] == SEL_W'(i) && addr_i[3:1] == 3'b011))
      |=> $stable(ch_cnt[i]));

    p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_fcmp[i] && !wr_en_i) |=> ch_fcmp[i]);

    p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (ch_fcmp[i] || ch_fovf[i]));

    p_pin_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[i] && !wr_en_i) |=> $stable(cmp_o[i]));
  end
endmodule

bind tmr_array tmr_array_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .run_q   (run_q),
  .ch_cnt  (ch_cnt),
  .ch_fcmp (ch_fcmp),
  .ch_fovf (ch_fovf),
  .cmp_o   (cmp_o),
  .irq_o   (irq_o)
);

// File: tb/tmr_array_tb_top.sv
`timescale 1ns/1ps
module tmr_array_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cmp, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [5:0] START = 6'h30;

  always #4 clk = ~clk;

  tmr_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cmp_o(cmp), .irq_o(irq)
  );

  function automatic logic [5:0] ca(input int ch, input int off);
    return 6'(ch * 16 + off);
  endfunction

  function automatic int ticks(input int dv, input int ed, input int k);
    int d = 1 << (2 * dv);
    if (d == 1) return k;
    if (ed == 1) return (k >= d / 2) ? (k - d / 2) / d + 1 : 0;
    if (ed == 2) return k / (d / 2);
    return k / d;
  endfunction

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_cnt(input int ch, output int v);
    logic [7:0] lo, hi;
    bus_rd(ca(ch, 6), lo);
    bus_rd(ca(ch, 7), hi);
    v = {hi, lo};
  endtask

  task automatic set16(input int ch, input int off, input int v);
    bus_wr(ca(ch, off), 8'(v));
    bus_wr(ca(ch, off + 1), 8'(v >> 8));
  endtask

  task automatic clr_flags(input int ch);
    logic [7:0] d;
    bus_rd(ca(ch, 5), d);
    bus_wr(ca(ch, 5), 8'h00);
  endtask

  // start with mask, wait w cycles, stop: k = w+1 counting edges
  task automatic run_for(input logic [7:0] mask, input int w);
    bus_wr(START, mask);
    repeat (w) @(negedge clk);
    bus_wr(START, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(int'(cmp), 0, "R1", "cmp_o");
    check(int'(irq), 0, "R1", "irq_o");
    bus_rd(START, d); check(d, 0, "R1", "run reg");
    for (int c = 0; c < 3; c++) begin
      bus_rd(ca(c, 0), d); check(d, 0, "R1", "ctrl");
      rd_cnt(c, v); check(v, 0, "R1", "counter");
    end

    // R7 overflow, R5 free-run wrap, R10 level irq
    bus_wr(ca(1, 0), 8'h00);
    set16(1, 8, 16'h1000);
    bus_wr(ca(1, 4), 8'h10);
    set16(1, 6, 16'hFFFE);
    run_for(8'h02, 1);
    check(irq[1], 1, "R10", "irq on overflow");
    // R9 write 0 without a read: flag kept
    bus_wr(ca(1, 5), 8'h00);
    bus_rd(ca(1, 5), d); check(d, 8'h10, "R9", "clear without read");
    rd_cnt(1, v); check(v, 0, "R7", "wrapped counter");
    bus_wr(ca(1, 5), 8'hFF);
    bus_rd(ca(1, 5), d); check(d, 8'h10, "R9", "write 1 no effect");
    bus_wr(ca(1, 5), 8'hEF);
    bus_rd(ca(1, 5), d); check(d, 8'h00, "R9", "read then write 0");
    check(irq[1], 0, "R10", "irq dropped");

    // R9 event between read and clearing write
    bus_wr(ca(0, 0), 8'h20);
    set16(0, 8, 5);
    set16(0, 6, 5);
    bus_wr(ca(0, 4), 8'h01);
    bus_rd(ca(0, 5), d); check(d, 0, "R9", "status before");
    run_for(8'h01, 0);
    check(irq[0], 1, "R6", "match irq");
    bus_wr(ca(0, 5), 8'h00);
    bus_rd(ca(0, 5), d); check(d, 8'h01, "R9", "late flag kept");
    bus_wr(ca(0, 5), 8'h00);
    bus_rd(ca(0, 5), d); check(d, 8'h00, "R9", "late flag cleared");
    rd_cnt(0, v); check(v, 0, "R5", "match clears counter");

    // R8 pin actions
    bus_wr(ca(2, 0), 8'h20);
    set16(2, 8, 3);
    set16(2, 6, 0);
    bus_wr(ca(2, 2), 8'h05);
    check(cmp[2], 1, "R8", "init level 1");
    run_for(8'h04, 3);
    check(cmp[2], 0, "R8", "clear on match");
    bus_wr(ca(2, 2), 8'h02);
    check(cmp[2], 0, "R8", "init level 0");
    run_for(8'h04, 3);
    check(cmp[2], 1, "R8", "set on match");
    bus_wr(ca(2, 2), 8'h00);
    check(cmp[2], 1, "R8", "code 0 keeps pin");
    run_for(8'h04, 3);
    check(cmp[2], 1, "R8", "code 0 no action");

    // R11 counter write beats tick
    bus_wr(ca(0, 0), 8'h00);
    set16(0, 6, 0);
    bus_wr(START, 8'h01);
    repeat (3) @(negedge clk);
    bus_wr(ca(0, 6), 8'h50);
    bus_wr(START, 8'h00);
    rd_cnt(0, v); check(v, 16'h0051, "R11", "write priority");

    // R3 prescaler restarts on each start; codes above 3 divide by 64
    bus_wr(ca(1, 0), 8'h03);
    set16(1, 6, 0);
    run_for(8'h02, 39);
    run_for(8'h02, 39);
    rd_cnt(1, v); check(v, 0, "R3", "prescaler restart");
    bus_wr(ca(1, 0), 8'h07);
    run_for(8'h02, 63);
    rd_cnt(1, v); check(v, 1, "R3", "code 7 div64");

    // R2 shared run register
    for (int c = 0; c < 3; c++) begin
      bus_wr(ca(c, 0), 8'h00);
      set16(c, 6, 0);
    end
    bus_wr(START, 8'h05);
    bus_rd(START, d); check(d, 5, "R2", "run readback");
    repeat (8) @(negedge clk);
    bus_wr(START, 8'h00);
    rd_cnt(0, v); check(v, 10, "R2", "ch0 ran");
    rd_cnt(1, v); check(v, 0, "R2", "ch1 held");
    rd_cnt(2, v); check(v, 10, "R2", "ch2 ran");

    // random periods over dividers and edges: R3 R4 R5 R6 R8 R10
    for (int it = 0; it < 30; it++) begin
      int ch = $urandom % 3;
      int dv = $urandom % 4;
      int ed = $urandom % 3;
      int gr = $urandom % 40;
      int w  = (dv == 3) ? ($urandom % 700) + 1 : ($urandom % 200) + 1;
      int t, ecnt;
      bus_wr(ca(ch, 0), {3'd1, 2'(ed), 3'(dv)});
      bus_wr(ca(ch, 2), 8'h03);
      bus_wr(ca(ch, 4), 8'h01);
      set16(ch, 8, gr);
      set16(ch, 6, 0);
      clr_flags(ch);
      run_for(8'(1 << ch), w);
      t = ticks(dv, ed, w + 1);
      ecnt = t % (gr + 1);
      rd_cnt(ch, v); check(v, ecnt, "R4 R5", "counter after run");
      check(irq[ch], (t >= gr + 1) ? 1 : 0, "R10", "irq level");
      check(cmp[ch], (t / (gr + 1)) % 2, "R8", "toggle pin");
      bus_rd(ca(ch, 5), d); check(d[0], (t >= gr + 1) ? 1 : 0, "R6", "compare flag");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule